// File: doc/BRIEF.md
# Pattern and Nametable Bank Router

This block turns a video fetch address into a CHR memory bank. It holds eight byte-wide bank registers and one style register, all loaded from the CPU write port. For every video fetch it picks the bank register that covers the address and drives CHR address bits 17-10. It also works out address bit 10, which a mirroring rule may replace. For a nametable fetch it chooses between CHR ROM and the console's internal nametable RAM (CIRAM).

The fetch path is purely combinational from `ppu_addr` to the outputs, so a fetch sees its bank in the same cycle. The CPU write port is a plain strobe with no back-pressure. A write with `cpu_wr_en` high is taken at the next rising clock edge and always accepted. Only the upper nibble of the CPU address and its two lowest bits are decoded. The parameter `SWAP_A0A1` exchanges those two low bits for boards that wire them the other way round.

Top module: `chr_bank_router`

## Requirements
- R1: After reset all eight bank registers and the style register read as zero. A pattern fetch at $0000 then gives bank $00 with the ROM select high. A fetch at $2400 gives bank $01 from CIRAM, with CIRAM A10 high.
- R2: A write with `cpu_addr[15:12]`=$D loads bank register 0-3, and a write with $E loads register 4-7. The register within the group is chosen by `cpu_addr[1:0]`, or by the swapped pair when `SWAP_A0A1`=1. `cpu_addr[15:12]`=$B together with low bits 3 loads the style register. All other address bits are ignored. Any other write, and any cycle with `cpu_wr_en` low, changes nothing. A write takes effect in the cycle after its clock edge.
- R3: Style bits [1:0]=0: the pattern slot at `ppu_addr[12:10]`=k uses register k as a 1 KB bank.
- R4: Style bits [1:0]=1: pattern space is four 2 KB slots that use registers 0, 1, 2 and 3 in address order.
- R5: Style bits [1:0]=2 or 3: the slots at $0000, $0400, $0800 and $0C00 use registers 0 to 3 as 1 KB banks. $1000-$17FF uses register 4 and $1800-$1FFF uses register 5, each as a 2 KB bank.
- R6: A fetch with `ppu_addr[13]`=1 is a nametable fetch, and $3000-$3FFF mirrors $2000-$2FFF. The slot at `ppu_addr[11:10]` takes its register from style bits [2:0], listed for slots 0 to 3. Values 1 and 5 give registers 4, 5, 6, 7. Values 2, 3 and 4 give 6, 7, 6, 7. Values 0, 6 and 7 give 6, 6, 7, 7.
- R7: In a 2 KB pattern slot, style bit 5 set makes CHR A10 follow `ppu_addr[10]`. With bit 5 clear, CHR A10 is the register LSB. A 1 KB slot always uses the register LSB.
- R8: On a nametable fetch with style bit 5 set, style bits [3:0] set CHR A10 as follows. $3 or $4 gives `ppu_addr[11]`. $B or $C gives 1. $0 or $7 gives `ppu_addr[10]`. $8 or $F gives 0. Any other value gives the register LSB.
- R9: Style bit 4 set sends nametable fetches to CHR ROM (`chr_rom_sel`=1). Bit 4 clear sends them to CIRAM (`ciram_sel`=1). Pattern fetches always go to CHR ROM. Exactly one select is high.
- R10: `ciram_a10` always equals `chr_bank[0]`. When a nametable fetch goes to CIRAM with style bit 5 clear, that bit follows `ppu_addr[10]` (vertical mirroring). A ROM nametable fetch with bit 5 clear uses the register LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register file |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU write strobe, one write per cycle |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 14 | Video fetch address A13-A0 |
| chr_bank | output | 8 | CHR address bits 17-10; bit 0 is the resolved A10 |
| chr_rom_sel | output | 1 | Fetch is served by CHR ROM |
| ciram_sel | output | 1 | Fetch is served by console nametable RAM |
| ciram_a10 | output | 1 | A10 for console nametable RAM |

## Verification
The bank registers are loaded so that neighbouring registers differ in their LSB. A design that forwards `ppu_addr[10]` where the register LSB belongs, or the reverse, therefore produces a wrong bank number. Each mirroring code is tried at an address where PPU A10, PPU A11 and the register LSB disagree. This exposes a design that mixes up the horizontal, vertical and one-screen sources, or that overrides a code it should leave alone. The bench also covers the nametable layouts for every style value class and the $3000 mirror. It writes through mirrored CPU addresses, and it sends writes to neighbouring pages and to the wrong low bits. A decoder that compares too few address bits would then corrupt a register or the style.

// File: rtl/chr_route_pkg.sv
package chr_route_pkg;
  localparam int NUM_BANK_REGS = 8;
  localparam int IDX_W         = $clog2(NUM_BANK_REGS);
  localparam int STYLE_W       = 6;
  // style register field positions
  localparam int STY_NT_ROM    = 4;
  localparam int STY_OVERRIDE  = 5;
  // CPU page codes seen on the upper address nibble
  localparam logic [3:0] PAGE_BANK_LO = 4'hD;
  localparam logic [3:0] PAGE_BANK_HI = 4'hE;
  localparam logic [3:0] PAGE_STYLE   = 4'hB;
  localparam logic [1:0] STYLE_SUBREG = 2'd3;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_route_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CPU_AW    = 16,
  parameter bit SWAP_A0A1 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CPU_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     bank_q [NUM_BANK_REGS],
  output logic [STYLE_W-1:0] style_q
);
  localparam int HALF = NUM_BANK_REGS / 2;

  logic [3:0] page;
  logic [1:0] sub;
  logic       unused_mid_addr;

  assign page = wr_addr[CPU_AW-1 -: 4];
  assign unused_mid_addr = ^wr_addr[CPU_AW-5:2];

  generate
    if (SWAP_A0A1) begin : g_swapped
      assign sub = {wr_addr[0], wr_addr[1]};
    end else begin : g_straight
      assign sub = wr_addr[1:0];
    end
  endgenerate

  for (genvar i = 0; i < NUM_BANK_REGS; i++) begin : g_bank
    localparam logic [3:0] MY_PAGE = (i < HALF) ? PAGE_BANK_LO : PAGE_BANK_HI;
    localparam logic [1:0] MY_SUB  = 2'(i % HALF);
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank_q[i] <= '0;
      else if (wr_en && page == MY_PAGE && sub == MY_SUB)
        bank_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      style_q <= '0;
    else if (wr_en && page == PAGE_STYLE && sub == STYLE_SUBREG)
      style_q <= wr_data[STYLE_W-1:0];
  end

  logic unused_style_data;
  assign unused_style_data = ^wr_data[DW-1:STYLE_W];
endmodule

// File: rtl/chr_slot_map.sv
module chr_slot_map
  import chr_route_pkg::*;
#(
  parameter int PPU_AW = 14
) (
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic [2:0]        mode_bits,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              two_k,
  output logic              is_nt
);
  localparam int NT_BIT   = PPU_AW - 1;
  localparam int SLOT_LSB = 10;

  logic [2:0] slot;
  logic [1:0] nt_slot;

  assign is_nt   = ppu_addr[NT_BIT];
  assign slot    = ppu_addr[SLOT_LSB +: 3];
  assign nt_slot = ppu_addr[SLOT_LSB +: 2];

  always_comb begin
    reg_idx = '0;
    two_k   = 1'b0;
    if (!is_nt) begin
      unique case (mode_bits[1:0])
        2'd0: reg_idx = slot;
        2'd1: begin
          reg_idx = {1'b0, slot[2:1]};
          two_k   = 1'b1;
        end
        default: begin
          if (!slot[2]) begin
            reg_idx = slot;
          end else begin
            reg_idx = {2'b10, slot[1]};
            two_k   = 1'b1;
          end
        end
      endcase
    end else begin
      unique case (mode_bits)
        3'd1, 3'd5:       reg_idx = {1'b1, nt_slot};
        3'd2, 3'd3, 3'd4: reg_idx = {2'b11, nt_slot[0]};
        default:          reg_idx = {2'b11, nt_slot[1]};
      endcase
    end
  end
endmodule

// File: rtl/chr_a10_sel.sv
module chr_a10_sel
  import chr_route_pkg::*;
(
  input  logic [STYLE_W-1:0] style,
  input  logic               is_nt,
  input  logic               two_k,
  input  logic               reg_lsb,
  input  logic               ppu_a10,
  input  logic               ppu_a11,
  output logic               a10
);
  logic ovr;
  assign ovr = style[STY_OVERRIDE];

  always_comb begin
    a10 = reg_lsb;
    if (!is_nt) begin
      if (two_k && ovr) a10 = ppu_a10;
    end else if (ovr) begin
      unique case (style[3:0])
        4'h0, 4'h7: a10 = ppu_a10;
        4'h3, 4'h4: a10 = ppu_a11;
        4'h8, 4'hF: a10 = 1'b0;
        4'hB, 4'hC: a10 = 1'b1;
        default:    a10 = reg_lsb;
      endcase
    end else if (!style[STY_NT_ROM]) begin
      a10 = ppu_a10;   // CIRAM without override: vertical arrangement
    end
  end
endmodule

// File: rtl/chr_bank_router.sv
module chr_bank_router
  import chr_route_pkg::*;
#(
  parameter int DW        = 8,
  parameter int CPU_AW    = 16,
  parameter int PPU_AW    = 14,
  parameter bit SWAP_A0A1 = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic [PPU_AW-1:0] ppu_addr,
  output logic [DW-1:0]     chr_bank,
  output logic              chr_rom_sel,
  output logic              ciram_sel,
  output logic              ciram_a10
);
  logic [DW-1:0]      bank_q [NUM_BANK_REGS];
  logic [STYLE_W-1:0] style_q;
  logic [IDX_W-1:0]   reg_idx;
  logic               two_k;
  logic               is_nt;
  logic [DW-1:0]      picked;
  logic               a10;
  logic               unused_low_ppu;

  assign unused_low_ppu = ^ppu_addr[9:0];

  chr_bank_regs #(.DW(DW), .CPU_AW(CPU_AW), .SWAP_A0A1(SWAP_A0A1)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cpu_wr_en),
    .wr_addr (cpu_addr),
    .wr_data (cpu_wdata),
    .bank_q  (bank_q),
    .style_q (style_q)
  );

  chr_slot_map #(.PPU_AW(PPU_AW)) u_map (
    .ppu_addr  (ppu_addr),
    .mode_bits (style_q[2:0]),
    .reg_idx   (reg_idx),
    .two_k     (two_k),
    .is_nt     (is_nt)
  );

  assign picked = bank_q[reg_idx];

  chr_a10_sel u_a10 (
    .style   (style_q),
    .is_nt   (is_nt),
    .two_k   (two_k),
    .reg_lsb (picked[0]),
    .ppu_a10 (ppu_addr[10]),
    .ppu_a11 (ppu_addr[11]),
    .a10     (a10)
  );

  assign chr_bank    = {picked[DW-1:1], a10};
  assign ciram_a10   = a10;
  assign ciram_sel   = is_nt && !style_q[STY_NT_ROM];
  assign chr_rom_sel = !ciram_sel;
endmodule

// File: rtl/chr_bank_router_checker.sv
module chr_bank_router_checker #(
  parameter int DW     = 8,
  parameter int PPU_AW = 14,
  parameter int STYLE_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_wr_en,
  input logic [PPU_AW-1:0]  ppu_addr,
  input logic [STYLE_W-1:0] style_q,
  input logic [DW-1:0]      chr_bank,
  input logic               chr_rom_sel,
  input logic               ciram_sel,
  input logic               ciram_a10
);
  logic nt_ovr;
  assign nt_ovr = ppu_addr[PPU_AW-1] && style_q[5];

  // R9: exactly one target selected
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    chr_rom_sel ^ ciram_sel);

  // R9: pattern fetches always go to ROM
  a_r9_pattern_rom: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_addr[PPU_AW-1] |-> chr_rom_sel);

  // R10: CIRAM without override is vertical
  a_r10_ciram_vertical: assert property (@(posedge clk) disable iff (!rst_n)
    (ciram_sel && !style_q[5]) |-> (ciram_a10 == ppu_addr[10]));

  // R8: one-screen low
  a_r8_screen_low: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_ovr && (style_q[3:0] == 4'h8 || style_q[3:0] == 4'hF)) |-> !chr_bank[0]);

  // R8: one-screen high
  a_r8_screen_high: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_ovr && (style_q[3:0] == 4'hB || style_q[3:0] == 4'hC)) |-> chr_bank[0]);

  // R8: horizontal arrangement
  a_r8_horizontal: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_ovr && (style_q[3:0] == 4'h3 || style_q[3:0] == 4'h4)) |-> (chr_bank[0] == ppu_addr[11]));

  // R7: 2 KB pattern slots pass A10 when override is set
  a_r7_two_k_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!ppu_addr[PPU_AW-1] && style_q[5] &&
     (style_q[1:0] == 2'd1 || (style_q[1] && ppu_addr[12]))) |-> (chr_bank[0] == ppu_addr[10]));

  // R2: without a write and with a steady address the bank holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cpu_wr_en) && $stable(ppu_addr)) |-> $stable(chr_bank));
endmodule

bind chr_bank_router chr_bank_router_checker #(.DW(DW), .PPU_AW(PPU_AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_wr_en   (cpu_wr_en),
  .ppu_addr    (ppu_addr),
  .style_q     (style_q),
  .chr_bank    (chr_bank),
  .chr_rom_sel (chr_rom_sel),
  .ciram_sel   (ciram_sel),
  .ciram_a10   (ciram_a10)
);

// File: tb/chr_bank_router_bench.sv
module chr_bank_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [13:0] ppu_addr = '0;
  logic [7:0]  chr_bank;
  logic        chr_rom_sel, ciram_sel, ciram_a10;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chr_bank_router u_chr_bank_router (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .ppu_addr(ppu_addr), .chr_bank(chr_bank),
    .chr_rom_sel(chr_rom_sel), .ciram_sel(ciram_sel), .ciram_a10(ciram_a10)
  );

  localparam logic [2:0] S_REG = 3'd0, S_A10 = 3'd1, S_A11 = 3'd2, S_LO = 3'd3, S_HI = 3'd4;
  localparam int NV = 46;
  // {req, style, ppu address, expected register, A10 source, ROM?}
  localparam logic [32:0] VEC [NV] = '{
    {4'd3,  8'h00, 14'h0000, 3'd0, S_REG, 1'b1},   // R3
    {4'd3,  8'h00, 14'h0400, 3'd1, S_REG, 1'b1},   // R3
    {4'd3,  8'h00, 14'h1C00, 3'd7, S_REG, 1'b1},   // R3
    {4'd3,  8'h20, 14'h1800, 3'd6, S_REG, 1'b1},   // R3 1 KB ignores bit 5
    {4'd4,  8'h21, 14'h0400, 3'd0, S_A10, 1'b1},   // R4
    {4'd4,  8'h21, 14'h0800, 3'd1, S_A10, 1'b1},   // R4
    {4'd4,  8'h21, 14'h1C00, 3'd3, S_A10, 1'b1},   // R4
    {4'd7,  8'h01, 14'h1400, 3'd2, S_REG, 1'b1},   // R7 bit 5 clear
    {4'd7,  8'h01, 14'h0800, 3'd1, S_REG, 1'b1},   // R7
    {4'd5,  8'h22, 14'h0C00, 3'd3, S_REG, 1'b1},   // R5
    {4'd5,  8'h22, 14'h1000, 3'd4, S_A10, 1'b1},   // R5
    {4'd5,  8'h23, 14'h1400, 3'd4, S_A10, 1'b1},   // R5
    {4'd5,  8'h23, 14'h1800, 3'd5, S_A10, 1'b1},   // R5
    {4'd7,  8'h02, 14'h1400, 3'd4, S_REG, 1'b1},   // R7
    {4'd6,  8'h10, 14'h2000, 3'd6, S_REG, 1'b1},   // R6
    {4'd6,  8'h10, 14'h2400, 3'd6, S_REG, 1'b1},   // R6
    {4'd6,  8'h10, 14'h2800, 3'd7, S_REG, 1'b1},   // R6
    {4'd6,  8'h10, 14'h2C00, 3'd7, S_REG, 1'b1},   // R6
    {4'd6,  8'h16, 14'h2800, 3'd7, S_REG, 1'b1},   // R6
    {4'd6,  8'h17, 14'h2000, 3'd6, S_REG, 1'b1},   // R6
    {4'd6,  8'h11, 14'h2000, 3'd4, S_REG, 1'b1},   // R6
    {4'd6,  8'h11, 14'h2400, 3'd5, S_REG, 1'b1},   // R6
    {4'd6,  8'h11, 14'h2800, 3'd6, S_REG, 1'b1},   // R6
    {4'd6,  8'h15, 14'h2C00, 3'd7, S_REG, 1'b1},   // R6
    {4'd6,  8'h12, 14'h2400, 3'd7, S_REG, 1'b1},   // R6
    {4'd6,  8'h12, 14'h2800, 3'd6, S_REG, 1'b1},   // R6
    {4'd6,  8'h13, 14'h2000, 3'd6, S_REG, 1'b1},   // R6
    {4'd6,  8'h14, 14'h2C00, 3'd7, S_REG, 1'b1},   // R6
    {4'd6,  8'h11, 14'h3400, 3'd5, S_REG, 1'b1},   // R6 mirror
    {4'd8,  8'h30, 14'h2400, 3'd6, S_A10, 1'b1},   // R8
    {4'd8,  8'h37, 14'h2800, 3'd7, S_A10, 1'b1},   // R8
    {4'd8,  8'h34, 14'h2800, 3'd6, S_A11, 1'b1},   // R8
    {4'd8,  8'h33, 14'h2400, 3'd7, S_A11, 1'b1},   // R8
    {4'd8,  8'h38, 14'h2C00, 3'd7, S_LO,  1'b1},   // R8
    {4'd8,  8'h3F, 14'h2800, 3'd7, S_LO,  1'b1},   // R8
    {4'd8,  8'h3C, 14'h2000, 3'd6, S_HI,  1'b1},   // R8
    {4'd8,  8'h3B, 14'h2800, 3'd6, S_HI,  1'b1},   // R8
    {4'd8,  8'h35, 14'h2800, 3'd6, S_REG, 1'b1},   // R8 not replaced
    {4'd8,  8'h3A, 14'h2000, 3'd6, S_REG, 1'b1},   // R8 not replaced
    {4'd9,  8'h20, 14'h2400, 3'd6, S_A10, 1'b0},   // R9 CIRAM
    {4'd9,  8'h24, 14'h2800, 3'd6, S_A11, 1'b0},   // R9
    {4'd10, 8'h00, 14'h2400, 3'd6, S_A10, 1'b0},   // R10 forced vertical
    {4'd10, 8'h04, 14'h2800, 3'd6, S_A10, 1'b0},   // R10
    {4'd10, 8'h07, 14'h2C00, 3'd7, S_A10, 1'b0},   // R10
    {4'd10, 8'h25, 14'h2800, 3'd6, S_REG, 1'b0},   // R10
    {4'd9,  8'h12, 14'h0400, 3'd1, S_REG, 1'b1}    // R9 pattern stays ROM
  };

  logic [7:0] rv [8];

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    cpu_wr_en = en; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic check(input string req, input logic [10:0] got, input logic [10:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [10:0] pack_exp(input logic [7:0] regv, input logic a10, input logic rom);
    return {regv[7:1], a10, rom, !rom, a10};
  endfunction

  function automatic logic [10:0] observed();
    return {chr_bank, chr_rom_sel, ciram_sel, ciram_a10};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) rv[i] = {4'(i + 1), 4'(i)};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    ppu_addr = 14'h0000; #1;
    check("R1 pattern", observed(), pack_exp(8'h00, 1'b0, 1'b1));
    ppu_addr = 14'h2400; #1;
    check("R1 nametable", observed(), pack_exp(8'h00, 1'b1, 1'b0));

    // R2: load through mirrored addresses
    wr(16'hD000, rv[0]); wr(16'hD7F1, rv[1]); wr(16'hDE6A, rv[2]); wr(16'hD003, rv[3]);
    wr(16'hE000, rv[4]); wr(16'hE101, rv[5]); wr(16'hE002, rv[6]); wr(16'hEFF3, rv[7]);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] src;
      logic [7:0] regv;
      logic       a10;
      wr(16'hB003, VEC[v][28:21]);
      ppu_addr = VEC[v][20:7];
      #1;
      regv = rv[VEC[v][6:4]];
      src  = VEC[v][3:1];
      unique case (src)
        S_A10:   a10 = ppu_addr[10];
        S_A11:   a10 = ppu_addr[11];
        S_LO:    a10 = 1'b0;
        S_HI:    a10 = 1'b1;
        default: a10 = regv[0];
      endcase
      check($sformatf("R%0d vector %0d", VEC[v][32:29], v), observed(), pack_exp(regv, a10, VEC[v][0]));
    end

    // R2: style through a mirror address
    wr(16'hBFF7, 8'h10);
    ppu_addr = 14'h2400; #1;
    check("R2 style mirror", observed(), pack_exp(rv[6], rv[6][0], 1'b1));

    // R2: ignored writes
    wr(16'hB003, 8'h00);
    wr(16'hC000, 8'hFF); wr(16'hF003, 8'hFF); wr(16'hB002, 8'hFF);
    wr(16'hA003, 8'hFF); wr(16'h9000, 8'hFF); wr(16'hD000, 8'hFF, 1'b0);
    ppu_addr = 14'h0000; #1;
    check("R2 ignored bank", observed(), pack_exp(rv[0], rv[0][0], 1'b1));
    ppu_addr = 14'h2400; #1;
    check("R2 ignored style", observed(), pack_exp(rv[6], 1'b1, 1'b0));

    // R2: new value visible right after the write edge
    ppu_addr = 14'h0C00;
    @(negedge clk);
    cpu_wr_en = 1'b1; cpu_addr = 16'hD003; cpu_wdata = 8'hA4; #1;
    check("R2 before edge", observed(), pack_exp(rv[3], rv[3][0], 1'b1));
    @(negedge clk);
    cpu_wr_en = 1'b0; #1;
    check("R2 after edge", observed(), pack_exp(8'hA4, 1'b0, 1'b1));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule